// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Occupancy Counts

This block moves stream words from a producer on one clock to a consumer on an unrelated clock. Each stored word holds the payload bytes together with every sideband field of the stream: the per-byte strobe and keep qualifiers, the end-of-packet marker, and the stream identifier, route and user fields. All of these come out exactly as they went in, and in the same order. The write and read pointers cross between the clock domains as Gray codes through two-flop synchronizers. Each side works out its own view of the occupancy from its own pointer and the synchronized copy of the other side's pointer.

Each side reports a count of stored words, and the two counts are conservative in opposite directions. The producer's count can lag behind reads, so it may report too many words but never too few. The consumer's count can lag behind writes, so it may report too few words but never too many. A programmable-full flag on the write side and a programmable-empty flag on the read side compare the local count with a threshold input. The read port is first-word-fall-through. A single active-low asynchronous reset is synchronized into each domain. After that synchronized release, each side keeps its handshake output low for a fixed settling window, counted in its own clock cycles.

Top module: `cdc_stream_fifo`

## Requirements
- R1: While reset is asserted and up to the end of the settling window, `s_tready` and `m_tvalid` are 0 and both counts are 0. `prog_empty` is 1 and `prog_full` is 0 whenever the thresholds are non-zero.
- R2: After the synchronized reset release in each domain (two clock edges), `s_tready` and `m_tvalid` stay 0 for `HOLD_CYCLES` further edges of that domain's own clock (default 60). After that they follow the FIFO state.
- R3: A word is accepted only on an `s_clk` edge where `s_tvalid` and `s_tready` are both 1. A word is delivered only on an `m_clk` edge where `m_tvalid` and `m_tready` are both 1. Words leave in the order they entered.
- R4: Every payload and sideband field returns unchanged: `tdata`, `tstrb`, `tkeep`, `tlast`, `tid`, `tdest` and `tuser`. Bit i of `tstrb` and of `tkeep` qualifies data bits [8i+7:8i].
- R5: `wr_count` (ADDR_W+1 bits) is never less than the true number of stored words and never more than 2^ADDR_W. Once the read side has been quiet for two `s_clk` edges, it equals the true occupancy.
- R6: `rd_count` (ADDR_W+1 bits) is never more than the true number of readable words. Once the write side has been quiet for two `m_clk` edges, it equals the true occupancy.
- R7: When `wr_count` equals 2^ADDR_W, `s_tready` is 0. Offered words are dropped, and neither the count nor the stored contents change.
- R8: When `rd_count` is 0, `m_tvalid` is 0. Asserting `m_tready` has no effect, and the next word written is still read back correctly.
- R9: `m_tvalid` rises without any request once a word is visible on the read side. While `m_tvalid` is 1 and `m_tready` is 0, all `m_t*` outputs hold their values.
- R10: `prog_full` is 1 exactly when `wr_count >= pf_thresh`.
- R11: `prog_empty` is 1 exactly when `rd_count <= pe_thresh`.
- R12: A write on an `s_clk` edge raises `wr_count` by one right after that same edge. A read on an `m_clk` edge lowers `rd_count` by one right after that same edge. Each count changes in the other direction only through the synchronized remote pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| s_clk | input | 1 | Write-side clock |
| m_clk | input | 1 | Read-side clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| s_tvalid | input | 1 | Producer has a word |
| s_tready | output | 1 | FIFO accepts a word |
| s_tdata | input | 8*DATA_BYTES | Payload in |
| s_tstrb | input | DATA_BYTES | Byte strobe in |
| s_tkeep | input | DATA_BYTES | Byte keep in |
| s_tlast | input | 1 | Packet end in |
| s_tid | input | ID_W | Stream identifier in |
| s_tdest | input | DEST_W | Route field in |
| s_tuser | input | USER_W | User sideband in |
| m_tvalid | output | 1 | Word available |
| m_tready | input | 1 | Consumer takes the word |
| m_tdata | output | 8*DATA_BYTES | Payload out |
| m_tstrb | output | DATA_BYTES | Byte strobe out |
| m_tkeep | output | DATA_BYTES | Byte keep out |
| m_tlast | output | 1 | Packet end out |
| m_tid | output | ID_W | Stream identifier out |
| m_tdest | output | DEST_W | Route field out |
| m_tuser | output | USER_W | User sideband out |
| wr_count | output | ADDR_W+1 | Write-side occupancy (never low) |
| rd_count | output | ADDR_W+1 | Read-side occupancy (never high) |
| pf_thresh | input | ADDR_W+1 | Programmable-full threshold (write domain) |
| pe_thresh | input | ADDR_W+1 | Programmable-empty threshold (read domain) |
| prog_full | output | 1 | Write-side threshold flag |
| prog_empty | output | 1 | Read-side threshold flag |

## Verification
Pushes and pops often land in the same stretch of cycles. While they overlap, each side's count moves by its own transfer and, at the same time, by the synchronized pointer of the other side. The bench provokes this by running a producer and a consumer together with different idle and stall patterns on clocks of 20 ns and 36 ns. On every falling edge it judges the counts against the bench's own tally of pushes and pops: the write count must be at least the tally and the read count at most the tally. Each word that arrives must also match the arithmetic payload for its index. A separate sweep fills the FIFO and then drains it one word at a time. After each step it checks the exact counts, and at every occupancy it checks both flags against every threshold value.

// File: rtl/cdc_fifo_pkg.sv
package cdc_fifo_pkg;
  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;

  function automatic ptr_t to_gray(ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t from_gray(ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/cdc_rst_sync.sv
module cdc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic stage_q, out_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_o = out_q;
endmodule

// File: rtl/cdc_ptr_sync.sv
module cdc_ptr_sync
  import cdc_fifo_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign bin_out = PW'(from_gray(ptr_t'(sync_q)));
endmodule

// File: rtl/cdc_fifo_store.sv
module cdc_fifo_store #(
  parameter int AW = 3,
  parameter int WW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cdc_fifo_push_ctl.sv
module cdc_fifo_push_ctl
  import cdc_fifo_pkg::*;
#(
  parameter int AW   = 3,
  parameter int HOLD = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          push,
  input  logic [AW:0]   rbin_sync,
  input  logic [AW:0]   thr,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic [AW:0]   count,
  output logic          pfull
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam int HW = $clog2(HOLD + 2);

  logic [HW-1:0] hold_q, hold_d;
  logic [PW-1:0] wbin_q, wbin_d, wgray_q, wgray_d;
  logic          settled;

  assign settled  = (hold_q == HW'(HOLD));
  assign count    = wbin_q - rbin_sync;
  assign in_ready = settled && (count != DEPTH);
  assign push     = in_valid && in_ready;
  assign pfull    = (count >= thr);
  assign waddr    = wbin_q[AW-1:0];
  assign wgray    = wgray_q;

  always_comb begin
    hold_d = hold_q;
    if (!settled) hold_d = hold_q + HW'(1);
    wbin_d  = wbin_q + PW'(push);
    wgray_d = PW'(to_gray(ptr_t'(wbin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      hold_q  <= hold_d;
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
    end
  end

  // R5: the write-side view never exceeds capacity
  p_wcount_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH);
  // R7: no acceptance while full
  p_full_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == DEPTH) |-> !in_ready);
  // R12: without a local push the write count can only fall
  p_wcount_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> count <= $past(count));
endmodule

// File: rtl/cdc_fifo_pop_ctl.sv
module cdc_fifo_pop_ctl
  import cdc_fifo_pkg::*;
#(
  parameter int AW   = 3,
  parameter int HOLD = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          pop,
  input  logic [AW:0]   wbin_sync,
  input  logic [AW:0]   thr,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [AW:0]   count,
  output logic          pempty
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH = PW'(1 << AW);
  localparam int HW = $clog2(HOLD + 2);

  logic [HW-1:0] hold_q, hold_d;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic          settled;

  assign settled   = (hold_q == HW'(HOLD));
  assign count     = wbin_sync - rbin_q;
  assign out_valid = settled && (count != '0);
  assign pop       = out_valid && out_ready;
  assign pempty    = (count <= thr);
  assign raddr     = rbin_q[AW-1:0];
  assign rgray     = rgray_q;

  always_comb begin
    hold_d = hold_q;
    if (!settled) hold_d = hold_q + HW'(1);
    rbin_d  = rbin_q + PW'(pop);
    rgray_d = PW'(to_gray(ptr_t'(rbin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      hold_q  <= hold_d;
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
    end
  end

  // R6: the read-side view never exceeds capacity
  p_rcount_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH);
  // R8: nothing offered while empty
  p_empty_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !out_valid);
  // R12: without a local pop the read count can only rise
  p_rcount_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !pop |=> count >= $past(count));
endmodule

// File: rtl/cdc_stream_fifo.sv
module cdc_stream_fifo #(
  parameter int DATA_BYTES  = 2,
  parameter int ID_W        = 2,
  parameter int DEST_W      = 2,
  parameter int USER_W      = 2,
  parameter int ADDR_W      = 3,
  parameter int HOLD_CYCLES = 60
) (
  input  logic                    s_clk,
  input  logic                    m_clk,
  input  logic                    arst_n,
  input  logic                    s_tvalid,
  output logic                    s_tready,
  input  logic [8*DATA_BYTES-1:0] s_tdata,
  input  logic [DATA_BYTES-1:0]   s_tstrb,
  input  logic [DATA_BYTES-1:0]   s_tkeep,
  input  logic                    s_tlast,
  input  logic [ID_W-1:0]         s_tid,
  input  logic [DEST_W-1:0]       s_tdest,
  input  logic [USER_W-1:0]       s_tuser,
  output logic                    m_tvalid,
  input  logic                    m_tready,
  output logic [8*DATA_BYTES-1:0] m_tdata,
  output logic [DATA_BYTES-1:0]   m_tstrb,
  output logic [DATA_BYTES-1:0]   m_tkeep,
  output logic                    m_tlast,
  output logic [ID_W-1:0]         m_tid,
  output logic [DEST_W-1:0]       m_tdest,
  output logic [USER_W-1:0]       m_tuser,
  output logic [ADDR_W:0]         wr_count,
  output logic [ADDR_W:0]         rd_count,
  input  logic [ADDR_W:0]         pf_thresh,
  input  logic [ADDR_W:0]         pe_thresh,
  output logic                    prog_full,
  output logic                    prog_empty
);
  localparam int DW = 8 * DATA_BYTES;
  localparam int WW = DW + 2 * DATA_BYTES + 1 + ID_W + DEST_W + USER_W;
  localparam int PW = ADDR_W + 1;

  logic              rst_n_w, rst_n_r, push, pop;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wbin_sync, rbin_sync;
  logic [WW-1:0]     wword, rword;

  assign wword = {s_tdata, s_tstrb, s_tkeep, s_tlast, s_tid, s_tdest, s_tuser};
  assign {m_tdata, m_tstrb, m_tkeep, m_tlast, m_tid, m_tdest, m_tuser} = rword;

  cdc_rst_sync u_rst_w (.clk(s_clk), .arst_n(arst_n), .rst_n_o(rst_n_w));
  cdc_rst_sync u_rst_r (.clk(m_clk), .arst_n(arst_n), .rst_n_o(rst_n_r));

  cdc_ptr_sync #(.PW(PW)) u_r2w (
    .clk(s_clk), .rst_n(rst_n_w), .gray_in(rgray), .bin_out(rbin_sync));
  cdc_ptr_sync #(.PW(PW)) u_w2r (
    .clk(m_clk), .rst_n(rst_n_r), .gray_in(wgray), .bin_out(wbin_sync));

  cdc_fifo_push_ctl #(.AW(ADDR_W), .HOLD(HOLD_CYCLES)) u_push (
    .clk(s_clk), .rst_n(rst_n_w), .in_valid(s_tvalid), .in_ready(s_tready),
    .push(push), .rbin_sync(rbin_sync), .thr(pf_thresh), .waddr(waddr),
    .wgray(wgray), .count(wr_count), .pfull(prog_full));

  cdc_fifo_pop_ctl #(.AW(ADDR_W), .HOLD(HOLD_CYCLES)) u_pop (
    .clk(m_clk), .rst_n(rst_n_r), .out_ready(m_tready), .out_valid(m_tvalid),
    .pop(pop), .wbin_sync(wbin_sync), .thr(pe_thresh), .raddr(raddr),
    .rgray(rgray), .count(rd_count), .pempty(prog_empty));

  cdc_fifo_store #(.AW(ADDR_W), .WW(WW)) u_store (
    .wclk(s_clk), .we(push), .waddr(waddr), .wdata(wword),
    .raddr(raddr), .rdata(rword));

  // R9: a stalled head word stays offered and unchanged
  p_stall_stable_r9: assert property (@(posedge m_clk) disable iff (!rst_n_r)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(rword)));
endmodule

// File: tb/cdc_stream_fifo_tb.sv
module cdc_stream_fifo_tb;
  localparam int AW = 3, NB = 2, DW = 16, DEPTH = 8, CW = AW + 1;
  localparam int WW = DW + 2 * NB + 1 + 2 + 2 + 2;

  logic s_clk = 1'b0, m_clk = 1'b0, arst_n = 1'b0;
  logic s_tvalid, s_tready, m_tvalid, m_tready, s_tlast, m_tlast;
  logic [DW-1:0] s_tdata, m_tdata;
  logic [NB-1:0] s_tstrb, s_tkeep, m_tstrb, m_tkeep;
  logic [1:0] s_tid, s_tdest, s_tuser, m_tid, m_tdest, m_tuser;
  logic [CW-1:0] wr_count, rd_count, pf_thresh, pe_thresh;
  logic prog_full, prog_empty;

  int checks = 0, fails = 0, wr_idx = 0, rd_idx = 0, pushed = 0, popped = 0;
  bit mon_on = 1'b0;

  always #10 s_clk = ~s_clk;
  always #18 m_clk = ~m_clk;

  cdc_stream_fifo u_dut (
    .s_clk(s_clk), .m_clk(m_clk), .arst_n(arst_n),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tstrb(s_tstrb), .s_tkeep(s_tkeep), .s_tlast(s_tlast), .s_tid(s_tid),
    .s_tdest(s_tdest), .s_tuser(s_tuser),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata),
    .m_tstrb(m_tstrb), .m_tkeep(m_tkeep), .m_tlast(m_tlast), .m_tid(m_tid),
    .m_tdest(m_tdest), .m_tuser(m_tuser),
    .wr_count(wr_count), .rd_count(rd_count), .pf_thresh(pf_thresh),
    .pe_thresh(pe_thresh), .prog_full(prog_full), .prog_empty(prog_empty));

  function automatic logic [WW-1:0] gen(int k);
    logic [DW-1:0] d;
    d = DW'(k * 4951 + 165);
    return {d, 2'(k), 2'(k >> 1), ((k % 4) == 3), 2'(k >> 2), 2'(k >> 3), 2'(k * 3)};
  endfunction

  function automatic logic [WW-1:0] seen();
    return {m_tdata, m_tstrb, m_tkeep, m_tlast, m_tid, m_tdest, m_tuser};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_one();
    @(negedge s_clk);
    {s_tdata, s_tstrb, s_tkeep, s_tlast, s_tid, s_tdest, s_tuser} = gen(wr_idx);
    s_tvalid = 1'b1;
    while (!s_tready) @(negedge s_clk);
    @(posedge s_clk);
    @(negedge s_clk);
    s_tvalid = 1'b0;
    wr_idx++;
    pushed++;
  endtask

  task automatic pop_one();
    @(negedge m_clk);
    while (!m_tvalid) @(negedge m_clk);
    // R3 order and R4 field integrity
    check(seen() == gen(rd_idx), "R3/R4 payload", 32'(seen()), 32'(gen(rd_idx)));
    m_tready = 1'b1;
    @(posedge m_clk);
    @(negedge m_clk);
    m_tready = 1'b0;
    rd_idx++;
    popped++;
  endtask

  task automatic sweep_thresholds(int occ);
    for (int t = 0; t <= DEPTH; t++) begin
      pf_thresh = CW'(t);
      pe_thresh = CW'(t);
      #1;
      check(prog_full == (occ >= t), "R10 prog_full", 32'(prog_full), 32'(occ >= t));
      check(prog_empty == (occ <= t), "R11 prog_empty", 32'(prog_empty), 32'(occ <= t));
    end
    pf_thresh = CW'(5);
    pe_thresh = CW'(2);
  endtask

  always @(negedge s_clk) if (mon_on)
    check(int'(wr_count) >= pushed - popped, "R5 wr_count low", 32'(wr_count), 32'(pushed - popped));
  always @(negedge m_clk) if (mon_on)
    check(int'(rd_count) <= pushed - popped, "R6 rd_count high", 32'(rd_count), 32'(pushed - popped));

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    s_tvalid = 1'b0; m_tready = 1'b0;
    {s_tdata, s_tstrb, s_tkeep, s_tlast, s_tid, s_tdest, s_tuser} = '0;
    pf_thresh = CW'(5); pe_thresh = CW'(2);
    repeat (3) @(negedge s_clk);
    // R1 reset state
    check(!s_tready, "R1 s_tready", 32'(s_tready), 0);
    check(!m_tvalid, "R1 m_tvalid", 32'(m_tvalid), 0);
    check(wr_count == 0, "R1 wr_count", 32'(wr_count), 0);
    check(rd_count == 0, "R1 rd_count", 32'(rd_count), 0);
    check(!prog_full, "R1 prog_full", 32'(prog_full), 0);
    check(prog_empty, "R1 prog_empty", 32'(prog_empty), 1);
    @(negedge s_clk);
    arst_n = 1'b1;
    fork
      begin
        repeat (61) @(posedge s_clk);
        @(negedge s_clk);
        check(!s_tready, "R2 write hold", 32'(s_tready), 0);
        repeat (2) @(posedge s_clk);
        @(negedge s_clk);
        check(s_tready, "R2 write release", 32'(s_tready), 1);
        push_one();
      end
      begin
        repeat (61) @(posedge m_clk);
        @(negedge m_clk);
        check(!m_tvalid, "R2 read hold", 32'(m_tvalid), 0);
        repeat (2) @(posedge m_clk);
        @(negedge m_clk);
        check(m_tvalid, "R2/R9 read release", 32'(m_tvalid), 1);
      end
    join
    pop_one();
    repeat (12) @(negedge s_clk);
    check(wr_count == 0 && rd_count == 0, "R5/R6 empty again", 32'({wr_count, rd_count}), 0);

    // fill sweep with the reader stalled
    for (int occ = 1; occ <= DEPTH; occ++) begin
      push_one();
      check(wr_count == CW'(occ), "R12 wr_count step", 32'(wr_count), 32'(occ));
      repeat (12) @(negedge s_clk);
      @(negedge m_clk);
      check(rd_count == CW'(occ), "R6 rd_count quiet", 32'(rd_count), 32'(occ));
      check(wr_count == CW'(occ), "R5 wr_count quiet", 32'(wr_count), 32'(occ));
      check(m_tvalid && seen() == gen(rd_idx), "R9 stalled head", 32'(seen()), 32'(gen(rd_idx)));
      sweep_thresholds(occ);
    end
    // R7 writes while full are dropped
    @(negedge s_clk);
    {s_tdata, s_tstrb, s_tkeep, s_tlast, s_tid, s_tdest, s_tuser} = gen(999);
    s_tvalid = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge s_clk);
      check(!s_tready, "R7 ready while full", 32'(s_tready), 0);
    end
    s_tvalid = 1'b0;
    check(wr_count == CW'(DEPTH), "R7 count while full", 32'(wr_count), DEPTH);

    // drain sweep
    for (int occ = DEPTH - 1; occ >= 0; occ--) begin
      pop_one();
      check(rd_count == CW'(occ), "R12 rd_count step", 32'(rd_count), 32'(occ));
      repeat (6) @(negedge s_clk);
      check(wr_count == CW'(occ), "R5 wr_count quiet", 32'(wr_count), 32'(occ));
      @(negedge m_clk);
      sweep_thresholds(occ);
    end
    // R8 reads while empty are ignored
    m_tready = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge m_clk);
      check(!m_tvalid, "R8 valid while empty", 32'(m_tvalid), 0);
    end
    m_tready = 1'b0;
    check(rd_count == 0, "R8 count while empty", 32'(rd_count), 0);
    push_one();
    pop_one();

    // concurrent traffic with mixed gaps and stalls
    mon_on = 1'b1;
    fork
      for (int i = 0; i < 150; i++) begin
        push_one();
        if (i % 3 == 0) repeat (2) @(negedge s_clk);
      end
      for (int i = 0; i < 150; i++) begin
        if (i % 5 < 2) repeat (3) @(negedge m_clk);
        pop_one();
      end
    join
    mon_on = 1'b0;
    repeat (12) @(negedge s_clk);
    check(wr_count == 0, "R5 final wr_count", 32'(wr_count), 0);
    check(rd_count == 0 && !m_tvalid, "R3 final empty", 32'({rd_count, m_tvalid}), 0);
    summary();
  end
endmodule